// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one bank of general-purpose pins, up to 32 wide, behind a plain 32-bit register port with a write strobe, an address and a combinational read path. Software sets any subset of output bits in a single store, with no read-modify-write. It does this through two half-word update ports. In each word written to these ports, the upper sixteen bits are protect flags and the lower sixteen bits are new values. A value lands only where its protect flag is clear.

Each pin has its own direction bit and its own output-enable bit. The pin driver turns on only when both bits are set. Otherwise the pad floats. The levels on the pins pass through a two-flop synchronizer and can be read from a read-only port. The bank index is a parameter that places the bank's registers in a shared address map. The pin count is also a parameter, so narrow banks are supported: bits above the count read as 0 and do not store.

Top module: `mask_gpio_bank`

## Requirements
- R1: A write to the lower update port (offset 8·BANK) sets output bit i (i = 0..15) to wdata[i] wherever wdata[16+i] is 0. It never changes output bits 16 to 31.
- R2: A write to the upper update port (offset 8·BANK + 4) sets output bit 16+i to wdata[i] wherever wdata[16+i] is 0. It never changes output bits 0 to 15.
- R3: A set protect flag keeps the old output value. A word whose upper half is all ones changes nothing.
- R4: Reading offset 0x60 + 4·BANK returns the pin levels, one bit per pin. A level held across two rising clock edges is visible after the second edge. It is not yet visible after the first edge.
- R5: The direction register at 0x204 + 0x40·BANK stores the written word and reads it back. A 1 marks a pin as an output.
- R6: The output-enable register at 0x208 + 0x40·BANK stores the written word and reads it back.
- R7: pin_oe[i] is 1 exactly when direction bit i and enable bit i are both 1. pin_o always shows the stored output value.
- R8: After reset, the output values, direction bits and enable bits are all 0.
- R9: The update ports read as 0. Any other offset reads as 0 and ignores writes. Writes to the direction and enable registers leave the output values unchanged.
- R10: With NPINS below 32, bits at and above NPINS read as 0 in every register and in the level port, and writes to them are dropped.
- R11: Each bank decodes only its own offsets, so a write meant for one bank has no effect on another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one store per cycle |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word for `addr`, combinational |
| pin_i | input | NPINS | Raw pin levels |
| pin_o | output | NPINS | Output values |
| pin_oe | output | NPINS | Per-pin driver enable |

## Verification
The bench walks a sequence of masked stores that mixes partial protect masks, a fully protected word and stores to non-data offsets. After each store it checks the whole output word. A design that swapped the roles of the protect and data halves, or let one half port spill into the other half, would show the wrong word right after that store. The bench probes the synchronizer depth one edge early and exactly on time, so a missing flop or an extra flop is caught. A second, 22-pin instance on bank 1 checks two things: that upper bits are cut off, and that one bank does not decode another bank's offsets. The enable gating is checked with direction and enable words that only partly overlap, so a design that used either bit alone would drive the wrong pins.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef struct packed {
        logic [31:0] outv;
        logic [31:0] dir;
        logic [31:0] oen;
    } gpb_state_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic lvl;
        logic dir;
        logic oen;
    } gpb_sel_t;

    // protect flags live in [31:16], new values in [15:0]
    function automatic logic [15:0] merge_half(input logic [15:0] old_v,
                                               input logic [31:0] word);
        return (old_v & word[31:16]) | (word[15:0] & ~word[31:16]);
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int BANK   = 0,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output gpb_sel_t          sel
);
    localparam logic [ADDR_W-1:0] OFF_LO  = ADDR_W'(8 * BANK);
    localparam logic [ADDR_W-1:0] OFF_HI  = ADDR_W'(8 * BANK + 4);
    localparam logic [ADDR_W-1:0] OFF_LVL = ADDR_W'(32'h060 + 4 * BANK);
    localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(32'h204 + 32'h40 * BANK);
    localparam logic [ADDR_W-1:0] OFF_OEN = ADDR_W'(32'h208 + 32'h40 * BANK);

    always_comb begin
        sel     = '0;
        sel.lo  = (addr == OFF_LO);
        sel.hi  = (addr == OFF_HI);
        sel.lvl = (addr == OFF_LVL);
        sel.dir = (addr == OFF_DIR);
        sel.oen = (addr == OFF_OEN);
    end
endmodule

// File: rtl/gpb_drive.sv
module gpb_drive #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] outv,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] oen,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] pin_oe
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign pin_o[g]  = outv[g];
        assign pin_oe[g] = dir[g] & oen[g];
    end
endmodule

// File: rtl/mask_gpio_bank.sv
module mask_gpio_bank
    import gpb_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int BANK   = 0,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe
);
    localparam logic [31:0] PIN_MASK = 32'((64'd1 << NPINS) - 64'd1);

    gpb_sel_t          sel;
    gpb_state_t        st_d, st_q;
    logic [NPINS-1:0]  lvl_sync;
    logic [31:0]       lvl_wide;

    gpb_decode #(.BANK(BANK), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    gpb_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (lvl_sync)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (sel.lo)  st_d.outv[15:0]  = merge_half(st_q.outv[15:0], wdata);
            if (sel.hi)  st_d.outv[31:16] = merge_half(st_q.outv[31:16], wdata);
            if (sel.dir) st_d.dir = wdata;
            if (sel.oen) st_d.oen = wdata;
        end
        st_d.outv = st_d.outv & PIN_MASK;
        st_d.dir  = st_d.dir  & PIN_MASK;
        st_d.oen  = st_d.oen  & PIN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lvl_wide              = '0;
        lvl_wide[NPINS-1:0]   = lvl_sync;
        rdata                 = '0;
        if (sel.lvl)      rdata = lvl_wide;
        else if (sel.dir) rdata = st_q.dir;
        else if (sel.oen) rdata = st_q.oen;
    end

    gpb_drive #(.NPINS(NPINS)) u_drv (
        .outv   (st_q.outv[NPINS-1:0]),
        .dir    (st_q.dir[NPINS-1:0]),
        .oen    (st_q.oen[NPINS-1:0]),
        .pin_o  (pin_o),
        .pin_oe (pin_oe)
    );

    // R1
    lo_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.lo) |=> $stable(st_q.outv[31:16]));

    // R2
    hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.hi) |=> $stable(st_q.outv[15:0]));

    // R3
    full_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.lo && wdata[31:16] == 16'hFFFF) |=> $stable(st_q.outv));

    // R5
    dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.dir) |=> (st_q.dir == ($past(wdata) & PIN_MASK)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: tb/mask_gpio_bank_tb.sv
module mask_gpio_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pin_i = '0;
    logic [31:0] rdata, p_o, p_oe;
    logic [31:0] rdata22;
    logic [21:0] q_o, q_oe;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mask_gpio_bank #(.NPINS(32), .BANK(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_i(pin_i), .pin_o(p_o), .pin_oe(p_oe));

    mask_gpio_bank #(.NPINS(22), .BANK(1)) dut22_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata22), .pin_i(pin_i[21:0]), .pin_o(q_o), .pin_oe(q_oe));

    // {addr, wdata, expected pin_o of bank 0}
    localparam logic [75:0] VEC [8] = '{
        {12'h000, 32'h0000_A5A5, 32'h0000_A5A5},
        {12'h004, 32'h0000_1234, 32'h1234_A5A5},
        {12'h000, 32'hFF00_00FF, 32'h1234_A5FF},
        {12'h004, 32'hFFFF_0000, 32'h1234_A5FF},
        {12'h004, 32'h0F0F_FFFF, 32'hF2F4_A5FF},
        {12'h000, 32'h0000_0000, 32'hF2F4_0000},
        {12'h204, 32'hFFFF_FFFF, 32'hF2F4_0000},
        {12'h100, 32'h0000_FFFF, 32'hF2F4_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        addr = a;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 out", p_o, 32'h0);
        chk("R8 oe", p_oe, 32'h0);
        rd(12'h204); chk("R8 dir", rdata, 32'h0);
        rd(12'h208); chk("R8 oen", rdata, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3 R9 via table
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][75:64], VEC[k][63:32]);
            chk("R1/R2/R3 table", p_o, VEC[k][31:0]);
        end

        // R9 read of update ports and unmapped
        rd(12'h000); chk("R9 lo read", rdata, 32'h0);
        rd(12'h004); chk("R9 hi read", rdata, 32'h0);
        rd(12'h100); chk("R9 unmapped", rdata, 32'h0);

        // R5 R6 R7
        wr(12'h204, 32'h0000_FFFF);
        wr(12'h208, 32'h00FF_00FF);
        rd(12'h204); chk("R5 dir", rdata, 32'h0000_FFFF);
        rd(12'h208); chk("R6 oen", rdata, 32'h00FF_00FF);
        chk("R7 oe", p_oe, 32'h0000_00FF);
        chk("R7 out", p_o, 32'hF2F4_0000);

        // R4 synchronizer depth
        rd(12'h060);
        @(negedge clk); pin_i = 32'hDEAD_BEEF;
        @(negedge clk); chk("R4 early", rdata, 32'h0);
        @(negedge clk); chk("R4 level", rdata, 32'hDEAD_BEEF);

        // R10 R11 narrow bank 1
        wr(12'h00C, 32'h0000_FFFF);
        chk("R10 hi pins", {10'h0, q_o}, 32'h003F_0000);
        chk("R11 bank0 untouched", p_o, 32'hF2F4_0000);
        wr(12'h244, 32'hFFFF_FFFF);
        rd(12'h244); chk("R10 dir", rdata22, 32'h003F_FFFF);
        rd(12'h204); chk("R11 bank0 dir", rdata, 32'h0000_FFFF);
        pin_i = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        rd(12'h064); chk("R10 level", rdata22, 32'h003F_FFFF);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule